// File: doc/BRIEF.md
# Host command framer and decoder

This block sits behind a host serial receiver and turns a stream of bytes into decoded commands. Message length is never counted up front. The top bit of every byte tells whether the message continues, and a byte with bit 7 clear closes it. The lead byte carries both the opcode and the upper argument bits. Short commands (point fire, ping, watchdog reset, power on/off) are decoded in the block. They come out as a one-cycle strobe with a 3-bit kind code and an argument of up to 10 bits. The argument is formed by joining the payload bits with the earlier byte more significant.

Two command families carry a variable payload: polarity setting and track-packet data. The block does not interpret their bytes. Every byte of such a message, lead byte included, goes out on a valid/ready payload stream with a family flag and an end marker. When a ping is accepted, the two-byte pong reply carrying the same tag is built and offered on a valid/ready transmit stream.

Back-pressure works as follows. A byte is taken on `rx_valid && rx_ready`. `rx_ready` is high whenever the single payload output register is empty or is being emptied in the same cycle (`pay_ready`), so a stalled payload consumer stalls the host. Payload and reply bytes stay stable while their valid is high and ready is low. Unknown or malformed input pulses `err`, and the framer discards bytes until one with bit 7 clear.

Top module: `hostcmd_framer`

## Requirements
- R1: After reset, `cmd_valid`, `err`, `pay_valid` and `tx_valid` are low and `rx_ready` is high.
- R2: Byte 0x21 alone gives a `cmd_valid` pulse with kind 4 (power on), and 0x20 gives kind 5 (power off). In both cases the argument is 0 and the strobe comes in the cycle after the byte is accepted.
- R3: Lead byte 0xA0|T[9:7] followed by byte 0x00|T[6:0] gives kind 1 (point fire) with argument T.
- R4: Lead byte 0x98 followed by 0x00|M gives kind 3 (watchdog reset) with argument M, the timeout in 16 ms units.
- R5: Lead byte 0x88|X[9:7] followed by X[6:0] gives kind 2 (ping) with argument X. The transmit stream then carries 0x88|X[9:7] and then X[6:0], in that order.
- R6: A ping that completes while the previous reply has not fully left pulses `err`, raises no `cmd_valid`, and leaves the pending reply unchanged.
- R7: A message with lead byte 0x90..0x97 (polarity, `pay_kind`=0) or 0xFF (track data, `pay_kind`=1) is passed on byte for byte, lead included, in order. `pay_last` is set only on the byte whose bit 7 is clear. On that byte's acceptance, kind 6 or 7 is strobed with the message's byte count as argument.
- R8: While `pay_valid` is high and `pay_ready` low, `rx_ready` is low and the payload outputs hold. No payload byte is lost or repeated.
- R9: A lead byte that matches no command pulses `err` once. If its bit 7 is set, the following bytes up to and including the next byte with bit 7 clear are ignored (no strobe, no payload), and the next message decodes normally.
- R10: A second byte of a two-byte command that has bit 7 set pulses `err`, gives no strobe, and starts discarding as in R9.
- R11: If a payload message reaches its maximum byte count (`POL_MAX_BYTES` or `NMRA_MAX_BYTES`) with bit 7 still set, that byte is forwarded with `pay_last` and `pay_abort` set. `err` pulses, no kind 6/7 strobe is raised, and the remainder is discarded.
- R12: `cmd_valid` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 8 | Byte from host receiver |
| rx_valid | input | 1 | Byte offered |
| rx_ready | output | 1 | Byte taken when valid is also high |
| cmd_valid | output | 1 | One-cycle decoded command strobe |
| cmd_kind | output | 3 | 1 point, 2 ping, 3 watchdog, 4 on, 5 off, 6 polarity, 7 track data |
| cmd_arg | output | 10 | Command argument or payload byte count |
| err | output | 1 | One-cycle error pulse |
| pay_data | output | 8 | Forwarded payload byte |
| pay_kind | output | 1 | 0 polarity, 1 track data |
| pay_last | output | 1 | Final byte of the forwarded message |
| pay_abort | output | 1 | Message cut at its length limit |
| pay_valid | output | 1 | Payload byte offered |
| pay_ready | input | 1 | Payload consumer takes the byte |
| tx_data | output | 8 | Reply byte to host |
| tx_valid | output | 1 | Reply byte offered |
| tx_ready | input | 1 | Transmitter takes the byte |

## Verification
The bench builds the block with `POL_MAX_BYTES`=3 and `NMRA_MAX_BYTES`=5. With these limits the overflow cut of R11 is hit by short messages, and random payload lengths regularly land exactly on the limit as well as below it. Random stall patterns on both output streams drive the back-pressure path of R8. A forced transmit stall holds a reply pending so that the second-ping rule of R6 can be reached.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int ARG_W = 10;
  localparam int LO_W  = 7;
  localparam int HI_W  = ARG_W - LO_W;

  typedef logic [ARG_W-1:0] arg_t;

  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_POINT = 3'd1,
    K_PING  = 3'd2,
    K_WDOG  = 3'd3,
    K_ON    = 3'd4,
    K_OFF   = 3'd5,
    K_POL   = 3'd6,
    K_NMRA  = 3'd7
  } kind_e;

  typedef enum logic [2:0] {
    C_BAD, C_ON, C_OFF, C_PAIR, C_POL, C_NMRA
  } lead_e;

  typedef enum logic [1:0] {
    S_LEAD, S_TAIL, S_FWD, S_SKIP
  } state_e;
endpackage

// File: rtl/hcf_lead_decode.sv
module hcf_lead_decode
  import hcf_pkg::*;
(
  input  logic [7:0] lead,
  output lead_e      cls,
  output kind_e      pair_kind
);
  always_comb begin
    cls       = C_BAD;
    pair_kind = K_NONE;
    if (lead == 8'h21) begin
      cls = C_ON;
    end else if (lead == 8'h20) begin
      cls = C_OFF;
    end else if (lead == 8'hFF) begin
      cls = C_NMRA;
    end else if (lead == 8'h98) begin
      cls       = C_PAIR;
      pair_kind = K_WDOG;
    end else if (lead[7:3] == 5'b10100) begin
      cls       = C_PAIR;
      pair_kind = K_POINT;
    end else if (lead[7:3] == 5'b10001) begin
      cls       = C_PAIR;
      pair_kind = K_PING;
    end else if (lead[7:3] == 5'b10010) begin
      cls = C_POL;
    end
  end
endmodule

// File: rtl/hcf_pay_stage.sv
module hcf_pay_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  input  logic         in_abort,
  input  logic         in_kind,
  output logic         space,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  output logic         out_abort,
  output logic         out_kind,
  input  logic         out_ready
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_abort <= 1'b0;
      out_kind  <= 1'b0;
    end else if (space) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= in_data;
        out_last  <= in_last;
        out_abort <= in_abort;
        out_kind  <= in_kind;
      end
    end
  end
endmodule

// File: rtl/hcf_pong.sv
module hcf_pong
  import hcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  arg_t       tag,
  output logic       busy,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready
);
  logic pend_q, hi_sent_q;
  arg_t tag_q;

  assign busy     = pend_q;
  assign tx_valid = pend_q;
  assign tx_data  = hi_sent_q ? {1'b0, tag_q[LO_W-1:0]}
                              : {5'b10001, tag_q[ARG_W-1:LO_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      hi_sent_q <= 1'b0;
      tag_q     <= '0;
    end else if (pend_q) begin
      if (tx_ready) begin
        if (hi_sent_q) begin
          pend_q    <= 1'b0;
          hi_sent_q <= 1'b0;
        end else begin
          hi_sent_q <= 1'b1;
        end
      end
    end else if (load) begin
      pend_q <= 1'b1;
      tag_q  <= tag;
    end
  end
endmodule

// File: rtl/hostcmd_framer.sv
module hostcmd_framer
  import hcf_pkg::*;
#(
  parameter int POL_MAX_BYTES  = 8,
  parameter int NMRA_MAX_BYTES = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic       cmd_valid,
  output logic [2:0] cmd_kind,
  output logic [9:0] cmd_arg,
  output logic       err,
  output logic [7:0] pay_data,
  output logic       pay_kind,
  output logic       pay_last,
  output logic       pay_abort,
  output logic       pay_valid,
  input  logic       pay_ready,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready
);
  localparam int MAXB  = (POL_MAX_BYTES > NMRA_MAX_BYTES) ? POL_MAX_BYTES : NMRA_MAX_BYTES;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam logic [CNT_W-1:0] POL_LAST  = CNT_W'(POL_MAX_BYTES - 1);
  localparam logic [CNT_W-1:0] NMRA_LAST = CNT_W'(NMRA_MAX_BYTES - 1);

  state_e           st_q;
  kind_e            pend_kind_q, cmd_kind_q;
  logic [HI_W-1:0]  hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic             nmra_q;
  logic             cmd_valid_q, err_q;
  arg_t             cmd_arg_q;

  lead_e cls;
  kind_e pair_kind;
  logic  space, accept, cont, at_limit, pong_busy, pong_load;
  logic  push, push_last, push_abort, push_kind;
  arg_t  pair_arg;

  hcf_lead_decode u_dec (.lead(rx_data), .cls(cls), .pair_kind(pair_kind));

  assign rx_ready = space;
  assign accept   = rx_valid && space;
  assign cont     = rx_data[7];
  assign at_limit = cnt_q == (nmra_q ? NMRA_LAST : POL_LAST);
  assign pair_arg = {hi_q, rx_data[LO_W-1:0]};

  always_comb begin
    push       = 1'b0;
    push_last  = 1'b0;
    push_abort = 1'b0;
    push_kind  = nmra_q;
    if (accept && st_q == S_LEAD && (cls == C_POL || cls == C_NMRA)) begin
      push      = 1'b1;
      push_kind = (cls == C_NMRA);
    end else if (accept && st_q == S_FWD) begin
      push       = 1'b1;
      push_last  = !cont || at_limit;
      push_abort = cont && at_limit;
    end
  end

  assign pong_load = accept && st_q == S_TAIL && !cont &&
                     pend_kind_q == K_PING && !pong_busy;

  hcf_pay_stage #(.W(8)) u_pay (
    .clk(clk), .rst(rst),
    .in_valid(push), .in_data(rx_data), .in_last(push_last),
    .in_abort(push_abort), .in_kind(push_kind), .space(space),
    .out_valid(pay_valid), .out_data(pay_data), .out_last(pay_last),
    .out_abort(pay_abort), .out_kind(pay_kind), .out_ready(pay_ready)
  );

  hcf_pong u_pong (
    .clk(clk), .rst(rst), .load(pong_load), .tag(pair_arg),
    .busy(pong_busy), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_LEAD;
      pend_kind_q <= K_NONE;
      hi_q        <= '0;
      cnt_q       <= '0;
      nmra_q      <= 1'b0;
      cmd_valid_q <= 1'b0;
      cmd_kind_q  <= K_NONE;
      cmd_arg_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      cmd_valid_q <= 1'b0;
      err_q       <= 1'b0;
      if (accept) begin
        unique case (st_q)
          S_LEAD: begin
            unique case (cls)
              C_ON, C_OFF: begin
                cmd_valid_q <= 1'b1;
                cmd_kind_q  <= (cls == C_ON) ? K_ON : K_OFF;
                cmd_arg_q   <= '0;
              end
              C_PAIR: begin
                pend_kind_q <= pair_kind;
                hi_q        <= rx_data[HI_W-1:0];
                st_q        <= S_TAIL;
              end
              C_POL, C_NMRA: begin
                nmra_q <= (cls == C_NMRA);
                cnt_q  <= CNT_W'(1);
                st_q   <= S_FWD;
              end
              default: begin
                err_q <= 1'b1;
                if (cont) st_q <= S_SKIP;
              end
            endcase
          end
          S_TAIL: begin
            if (cont) begin
              err_q <= 1'b1;
              st_q  <= S_SKIP;
            end else begin
              st_q <= S_LEAD;
              if (pend_kind_q == K_PING && pong_busy) begin
                err_q <= 1'b1;
              end else begin
                cmd_valid_q <= 1'b1;
                cmd_kind_q  <= pend_kind_q;
                cmd_arg_q   <= pair_arg;
              end
            end
          end
          S_FWD: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (!cont) begin
              cmd_valid_q <= 1'b1;
              cmd_kind_q  <= nmra_q ? K_NMRA : K_POL;
              cmd_arg_q   <= arg_t'(cnt_q) + arg_t'(1);
              st_q        <= S_LEAD;
            end else if (at_limit) begin
              err_q <= 1'b1;
              st_q  <= S_SKIP;
            end
          end
          default: begin
            if (!cont) st_q <= S_LEAD;
          end
        endcase
      end
    end
  end

  assign cmd_valid = cmd_valid_q;
  assign cmd_kind  = cmd_kind_q;
  assign cmd_arg   = cmd_arg_q;
  assign err       = err_q;
endmodule

// File: rtl/hcf_checker.sv
module hcf_checker (
  input logic       clk,
  input logic       rst,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       cmd_valid,
  input logic       err,
  input logic [7:0] pay_data,
  input logic       pay_last,
  input logic       pay_abort,
  input logic       pay_valid,
  input logic       pay_ready,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready
);
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && err));

  p_cmd_cause_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(rx_valid && rx_ready));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rx_valid && rx_ready));

  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && !pay_ready) |-> !rx_ready);

  p_pay_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && !pay_ready) |=>
      (pay_valid && $stable(pay_data) && $stable(pay_last) && $stable(pay_abort)));

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_abort_last_r11: assert property (@(posedge clk) disable iff (rst)
    (pay_valid && pay_abort) |-> pay_last);
endmodule

bind hostcmd_framer hcf_checker u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .cmd_valid(cmd_valid), .err(err), .pay_data(pay_data),
  .pay_last(pay_last), .pay_abort(pay_abort), .pay_valid(pay_valid),
  .pay_ready(pay_ready), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready)
);

// File: tb/sim_hostcmd_framer.sv
module sim_hostcmd_framer;
  localparam int POLM  = 3;
  localparam int NMRAM = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0, rx_ready;
  logic       cmd_valid, err, pay_kind, pay_last, pay_abort, pay_valid, tx_valid;
  logic [2:0] cmd_kind;
  logic [9:0] cmd_arg;
  logic [7:0] pay_data, tx_data;
  logic       pay_ready = 1'b0, tx_ready = 1'b0;
  logic       pay_hold = 1'b0, tx_hold = 1'b0;

  hostcmd_framer #(.POL_MAX_BYTES(POLM), .NMRA_MAX_BYTES(NMRAM)) u0 (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_arg(cmd_arg), .err(err), .pay_data(pay_data), .pay_kind(pay_kind),
    .pay_last(pay_last), .pay_abort(pay_abort), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  int checks = 0, failures = 0, cyc = 0;
  int ncmd = 0, nerr = 0, npay = 0, ntx = 0, nboth = 0;
  int cmd_k [0:1023];
  int cmd_a [0:1023];
  int pay_d [0:4095];
  int pay_f [0:4095];
  int tx_d  [0:1023];
  int msg   [0:31];
  int msg_len = 0;

  // Log of everything leaving the block, taken away from the clock edge.
  always @(negedge clk) if (!rst) begin
    if (cmd_valid && err) nboth++;
    if (cmd_valid) begin
      cmd_k[ncmd % 1024] = int'(cmd_kind);
      cmd_a[ncmd % 1024] = int'(cmd_arg);
      ncmd++;
    end
    if (err) nerr++;
    if (pay_valid && pay_ready) begin
      pay_d[npay % 4096] = int'(pay_data);
      pay_f[npay % 4096] = {29'd0, pay_abort, pay_last, pay_kind};
      npay++;
    end
    if (tx_valid && tx_ready) begin
      tx_d[ntx % 1024] = int'(tx_data);
      ntx++;
    end
  end

  always @(posedge clk) begin
    #2;
    pay_ready = pay_hold ? 1'b0 : (($urandom % 4) != 0);
    tx_ready  = tx_hold  ? 1'b0 : (($urandom % 3) != 0);
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: run hung actual=%0d expected<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int pair_arg(int b0, int b1);
    return ((b0 & 7) << 7) | (b1 & 'h7f);
  endfunction
  function automatic int pong_hi(int x);
    return 'h88 | ((x >> 7) & 7);
  endfunction
  function automatic int pong_lo(int x);
    return x & 'h7f;
  endfunction

  task automatic send_msg();
    for (int i = 0; i < msg_len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = msg[i][7:0];
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_pay(int target);
    for (int i = 0; i < 300 && npay < target; i++) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 300 && tx_valid; i++) @(negedge clk);
  endtask

  task automatic check_cmd(string req, int c0, int e0, int kind, int arg);
    chk(req, "strobe count", ncmd, c0 + 1);
    chk(req, "error count", nerr, e0);
    chk(req, "kind", cmd_k[c0 % 1024], kind);
    chk(req, "arg", cmd_a[c0 % 1024], arg);
  endtask

  task automatic check_stream(string req, int p0, int kindbit);
    wait_pay(p0 + msg_len);
    chk(req, "payload byte count", npay, p0 + msg_len);
    for (int i = 0; i < msg_len; i++) begin
      chk(req, "payload byte", pay_d[(p0 + i) % 4096], msg[i]);
      chk(req, "payload flags", pay_f[(p0 + i) % 4096],
          ((i == msg_len - 1) ? 2 : 0) | kindbit);
    end
  endtask

  task automatic send_stream(bit nmra, int len);
    msg_len = len;
    msg[0]  = nmra ? 'hFF : ('h90 | ($urandom % 8));
    for (int i = 1; i < len; i++)
      msg[i] = (i == len - 1) ? ($urandom % 128) : ('h80 | ($urandom % 128));
  endtask

  int c0, e0, p0, t0, x, bp_done;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "cmd_valid in reset", int'(cmd_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rx_ready", int'(rx_ready), 1);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);
    chk("R1", "err", int'(err), 0);
    chk("R1", "pay_valid", int'(pay_valid), 0);
    chk("R1", "tx_valid", int'(tx_valid), 0);

    // R2: power on / off
    c0 = ncmd; e0 = nerr; msg_len = 1; msg[0] = 'h21; send_msg();
    check_cmd("R2", c0, e0, 4, 0);
    c0 = ncmd; msg[0] = 'h20; send_msg();
    check_cmd("R2", c0, e0, 5, 0);

    // R3: point fire at both argument extremes
    c0 = ncmd; msg_len = 2; msg[0] = 'hA7; msg[1] = 'h7F; send_msg();
    check_cmd("R3", c0, e0, 1, 'h3FF);
    c0 = ncmd; msg[0] = 'hA0; msg[1] = 'h00; send_msg();
    check_cmd("R3", c0, e0, 1, 0);

    // R4: watchdog
    c0 = ncmd; msg[0] = 'h98; msg[1] = 'h7F; send_msg();
    check_cmd("R4", c0, e0, 3, 'h7F);

    // R5 and R6: ping with the reply held back, then a second ping
    tx_hold = 1'b1;
    c0 = ncmd; t0 = ntx; x = 'h2A5;
    msg[0] = pong_hi(x); msg[1] = pong_lo(x); send_msg();
    check_cmd("R5", c0, e0, 2, x);
    c0 = ncmd;
    msg[0] = pong_hi('h111); msg[1] = pong_lo('h111); send_msg();
    chk("R6", "error on early ping", nerr, e0 + 1);
    chk("R6", "no strobe on early ping", ncmd, c0);
    e0 = nerr;
    tx_hold = 1'b0;
    for (int i = 0; i < 300 && ntx < t0 + 2; i++) @(negedge clk);
    chk("R5", "reply byte count", ntx, t0 + 2);
    chk("R5", "reply high byte", tx_d[t0 % 1024], pong_hi(x));
    chk("R6", "reply keeps first tag", tx_d[(t0 + 1) % 1024], pong_lo(x));

    // R9: unknown lead with continuation; 0x21 in the tail must be ignored
    c0 = ncmd; p0 = npay;
    msg_len = 3; msg[0] = 'h99; msg[1] = 'hFF; msg[2] = 'h21; send_msg();
    chk("R9", "error pulses", nerr, e0 + 1);
    chk("R9", "no strobe from skipped bytes", ncmd, c0);
    chk("R9", "no payload from skipped bytes", npay, p0);
    e0 = nerr;
    msg_len = 1; msg[0] = 'h05; send_msg();
    chk("R9", "single-byte unknown error", nerr, e0 + 1);
    e0 = nerr;
    c0 = ncmd; msg[0] = 'h21; send_msg();
    check_cmd("R9", c0, e0, 4, 0);

    // R10: continuation set in the second byte of a pair
    c0 = ncmd;
    msg_len = 3; msg[0] = 'hA0; msg[1] = 'h81; msg[2] = 'h20; send_msg();
    chk("R10", "error pulses", nerr, e0 + 1);
    chk("R10", "no strobe", ncmd, c0);
    e0 = nerr;

    // R11: polarity message running past its limit
    c0 = ncmd; p0 = npay;
    msg_len = 5; msg[0] = 'h91; msg[1] = 'h85; msg[2] = 'h86; msg[3] = 'h87; msg[4] = 'h21;
    send_msg();
    wait_pay(p0 + POLM);
    repeat (10) @(negedge clk);
    chk("R11", "bytes forwarded", npay, p0 + POLM);
    chk("R11", "cut byte", pay_d[(p0 + POLM - 1) % 4096], 'h86);
    chk("R11", "cut flags last+abort", pay_f[(p0 + POLM - 1) % 4096], 6);
    chk("R11", "error pulses", nerr, e0 + 1);
    chk("R11", "no strobe", ncmd, c0);
    e0 = nerr;

    // R8: consumer stalled during a track-data message
    pay_hold = 1'b1; bp_done = 0;
    c0 = ncmd; p0 = npay;
    msg_len = 3; msg[0] = 'hFF; msg[1] = 'h81; msg[2] = 'h05;
    fork
      begin send_msg(); bp_done = 1; end
    join_none
    repeat (8) @(negedge clk);
    chk("R8", "rx_ready while stalled", int'(rx_ready), 0);
    chk("R8", "pay_valid while stalled", int'(pay_valid), 1);
    chk("R8", "sender blocked", bp_done, 0);
    pay_hold = 1'b0;
    for (int i = 0; i < 300 && bp_done == 0; i++) @(negedge clk);
    check_stream("R8", p0, 1);
    check_cmd("R7", c0, e0, 7, 3);

    // Random mix under random stalls on both outputs
    for (int it = 0; it < 200; it++) begin
      int t;
      t = $urandom % 7;
      c0 = ncmd; e0 = nerr; p0 = npay;
      case (t)
        0: begin msg_len = 1; msg[0] = 'h21; send_msg(); check_cmd("R2", c0, e0, 4, 0); end
        1: begin msg_len = 1; msg[0] = 'h20; send_msg(); check_cmd("R2", c0, e0, 5, 0); end
        2: begin
          x = $urandom % 1024;
          msg_len = 2; msg[0] = 'hA0 | (x >> 7); msg[1] = x & 'h7F; send_msg();
          check_cmd("R3", c0, e0, 1, pair_arg(msg[0], msg[1]));
        end
        3: begin
          x = $urandom % 128;
          msg_len = 2; msg[0] = 'h98; msg[1] = x; send_msg();
          check_cmd("R4", c0, e0, 3, x);
        end
        4: begin
          wait_tx_idle();
          t0 = ntx; x = $urandom % 1024;
          msg_len = 2; msg[0] = pong_hi(x); msg[1] = pong_lo(x); send_msg();
          check_cmd("R5", c0, e0, 2, x);
          for (int i = 0; i < 300 && ntx < t0 + 2; i++) @(negedge clk);
          chk("R5", "reply high", tx_d[t0 % 1024], pong_hi(x));
          chk("R5", "reply low", tx_d[(t0 + 1) % 1024], pong_lo(x));
        end
        5: begin
          send_stream(1'b0, 2 + ($urandom % (POLM - 1)));
          send_msg(); check_stream("R7", p0, 0);
          check_cmd("R7", c0, e0, 6, msg_len);
        end
        default: begin
          send_stream(1'b1, 2 + ($urandom % (NMRAM - 1)));
          send_msg(); check_stream("R7", p0, 1);
          check_cmd("R7", c0, e0, 7, msg_len);
        end
      endcase
    end

    chk("R12", "cycles with strobe and error together", nboth, 0);
    summary();
    $finish;
  end
endmodule